// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block takes seven level-sensitive interrupt inputs and steers them onto a small set of outgoing interrupt lines through six vector registers, one per source. Each vector holds a target server number, a priority and a 3-bit line selector, and it reports a pending flag. Inputs 0 and 1 share vector 0, and therefore one line. Inputs 2 to 6 use vectors 1 to 5.

Software programs a vector through a single-cycle write port. A combinational read port returns any vector in its packed layout, together with the decoded server and priority. The block also keeps a registered status bit for each input, laid out at fixed bit positions in two status words. A priority of all ones masks a source. In that case the source still drives its line, but the vector shows no pending flag. The pending flag always equals "line active and unmasked". It is not a latched event.

Top module: `vec_irq_router`

## Requirements
- R1: Reset state. Every vector has server 0, priority 0xFF, selector equal to its own index (0 to 5) and a clear pending flag. All lines and all status bits are 0.
- R2: Packed vector layout. Server is in bits 55:40, priority in bits 39:32, selector in bits 31:29 and the pending flag in bit 24. All other bits read 0. A write to a vector index from 0 to 5 updates only the server, priority and selector fields. The pending bit and the other bits of the write data are ignored. Writes to index 6 or 7 change nothing. Reading index 6 or 7 returns 0.
- R3: Status bits follow the inputs one clock after sampling. Input 0 appears at bit 47 and input 1 at bit 46 of the shared status word. Inputs 2, 3, 4, 5 and 6 appear at bits 36, 35, 34, 33 and 32 of the source status word. All other bits are 0.
- R4: An asserted input raises, one clock later, the line chosen by its vector's selector. The selector takes effect from the same clock edge at which it is written.
- R5: Vector 0 is active while either input 0 or input 1 is asserted. Its line and its pending flag stay asserted until both inputs are low.
- R6: Each line is the OR of all active vectors that select it. A line with no active selecting vector is 0.
- R7: The pending flag of a vector is 1 exactly when the vector was active at the last clock edge and its priority is not 0xFF.
- R8: Writing priority 0xFF to an active vector clears its pending flag at that same clock edge. Its line stays driven.
- R9: A selector value of 6 or 7, that is at or above the number of lines, drives no line.
- R10: The decoded server output is the server field of the vector being read, shifted right by 2. The decoded priority output is its priority field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 7 | Level interrupt inputs; bits 0 and 1 share vector 0 |
| wr_en | input | 1 | Vector write strobe |
| wr_idx | input | 3 | Vector index to write |
| wr_data | input | 64 | Packed vector write data |
| rd_idx | input | 3 | Vector index to read |
| rd_data | output | 64 | Packed vector with pending flag |
| rd_server | output | 14 | Effective server of the read vector |
| rd_prio | output | 8 | Priority of the read vector |
| line_out | output | 6 | Registered outgoing interrupt lines |
| mux_stat_word | output | 64 | Status of inputs 0 and 1 at bits 47 and 46 |
| src_stat_word | output | 64 | Status of inputs 2 to 6 at bits 36 down to 32 |

## Verification
The lines, the status bits and the pending flags are due one clock edge after the inputs or the write that caused them. The read-port outputs are combinational views of the state registered at the last edge. The bench samples every output at the falling clock edge and compares it against a behavioural model, which advances by exactly one step for each rising edge. The model applies each write before it evaluates lines and pending, so a same-edge selector change or masking write is expected at the very next sample.

// File: rtl/vec_irq_router.sv
module vec_irq_router #(
  parameter int NUM_VEC   = 6,
  parameter int NUM_LINES = 6,
  parameter int SRV_W     = 16,
  parameter int PRI_W     = 8,
  parameter int SEL_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_VEC:0]     irq_in,
  input  logic                 wr_en,
  input  logic [SEL_W-1:0]     wr_idx,
  input  logic [63:0]          wr_data,
  input  logic [SEL_W-1:0]     rd_idx,
  output logic [63:0]          rd_data,
  output logic [SRV_W-3:0]     rd_server,
  output logic [PRI_W-1:0]     rd_prio,
  output logic [NUM_LINES-1:0] line_out,
  output logic [63:0]          mux_stat_word,
  output logic [63:0]          src_stat_word
);
  localparam int NUM_IN  = NUM_VEC + 1;
  localparam int SRV_LO  = 40;
  localparam int PRI_LO  = 32;
  localparam int SEL_LO  = 29;
  localparam int PEND_B  = 24;
  localparam int MUXA_B  = 47;
  localparam int MUXB_B  = 46;
  localparam int SRC_HI  = 32 + NUM_VEC - 2;

  logic [SRV_W-1:0] srv_q [NUM_VEC];
  logic [PRI_W-1:0] pri_q [NUM_VEC];
  logic [SEL_W-1:0] sel_q [NUM_VEC];
  logic [SRV_W-1:0] srv_n [NUM_VEC];
  logic [PRI_W-1:0] pri_n [NUM_VEC];
  logic [SEL_W-1:0] sel_n [NUM_VEC];
  logic [NUM_VEC-1:0]   pend_q, pend_n, act;
  logic [NUM_IN-1:0]    stat_q;
  logic [NUM_LINES-1:0] line_n;

  assign act = {irq_in[NUM_IN-1:2], irq_in[1] | irq_in[0]};

  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      srv_n[v] = srv_q[v];
      pri_n[v] = pri_q[v];
      sel_n[v] = sel_q[v];
      if (wr_en && wr_idx == SEL_W'(v)) begin
        srv_n[v] = wr_data[SRV_LO +: SRV_W];
        pri_n[v] = wr_data[PRI_LO +: PRI_W];
        sel_n[v] = wr_data[SEL_LO +: SEL_W];
      end
      pend_n[v] = act[v] && (pri_n[v] != '1);
    end
    line_n = '0;
    for (int l = 0; l < NUM_LINES; l++)
      for (int v = 0; v < NUM_VEC; v++)
        if (act[v] && sel_n[v] == SEL_W'(l)) line_n[l] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VEC; v++) begin
        srv_q[v] <= '0;
        pri_q[v] <= '1;
        sel_q[v] <= SEL_W'(v);
      end
      pend_q   <= '0;
      stat_q   <= '0;
      line_out <= '0;
    end else begin
      for (int v = 0; v < NUM_VEC; v++) begin
        srv_q[v] <= srv_n[v];
        pri_q[v] <= pri_n[v];
        sel_q[v] <= sel_n[v];
      end
      pend_q   <= pend_n;
      stat_q   <= irq_in;
      line_out <= line_n;
    end
  end

  always_comb begin
    rd_data   = '0;
    rd_server = '0;
    rd_prio   = '0;
    for (int v = 0; v < NUM_VEC; v++)
      if (rd_idx == SEL_W'(v)) begin
        rd_data[SRV_LO +: SRV_W] = srv_q[v];
        rd_data[PRI_LO +: PRI_W] = pri_q[v];
        rd_data[SEL_LO +: SEL_W] = sel_q[v];
        rd_data[PEND_B]          = pend_q[v];
        rd_server = srv_q[v][SRV_W-1:2];
        rd_prio   = pri_q[v];
      end
  end

  always_comb begin
    mux_stat_word         = '0;
    mux_stat_word[MUXA_B] = stat_q[0];
    mux_stat_word[MUXB_B] = stat_q[1];
    src_stat_word         = '0;
    for (int i = 2; i < NUM_IN; i++)
      src_stat_word[SRC_HI - (i - 2)] = stat_q[i];
  end
endmodule

// File: rtl/vec_irq_router_chk.sv
module vec_irq_router_chk #(
  parameter int NL = 6,
  parameter int NI = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NI-1:0] irq_in,
  input logic [NL-1:0] line_out,
  input logic [63:0]   mux_stat_word,
  input logic [63:0]   rd_data,
  input logic [7:0]    rd_prio
);
  assert_line_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_out) |-> $past(|irq_in));

  assert_quiet_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in == '0) |=> (line_out == '0));

  assert_mux_status_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in[0] |=> mux_stat_word[47]);

  assert_mux_status_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_in[1] |=> !mux_stat_word[46]);

  assert_masked_not_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_prio == 8'hFF) |-> !rd_data[24]);
endmodule

bind vec_irq_router vec_irq_router_chk #(.NL(NUM_LINES), .NI(NUM_VEC + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .line_out(line_out),
  .mux_stat_word(mux_stat_word), .rd_data(rd_data), .rd_prio(rd_prio)
);

// File: tb/vec_irq_router_tb.sv
`timescale 1ns/1ps
module vec_irq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_in = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [63:0] rd_data, mux_stat_word, src_stat_word;
  logic [13:0] rd_server;
  logic [7:0]  rd_prio;
  logic [5:0]  line_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int unsigned m_srv [6];
  int unsigned m_pri [6];
  int unsigned m_sel [6];
  bit m_pend [6];
  bit m_stat [7];
  bit m_line [6];

  always #2.5 clk = ~clk;

  vec_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .rd_server(rd_server),
    .rd_prio(rd_prio), .line_out(line_out), .mux_stat_word(mux_stat_word),
    .src_stat_word(src_stat_word)
  );

  task automatic chk(string tag, logic [63:0] act_v, logic [63:0] exp_v);
    n_cmp++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  function automatic logic [63:0] exp_word(int v);
    logic [63:0] w = '0;
    if (v < 6) begin
      w[55:40] = 16'(m_srv[v]);
      w[39:32] = 8'(m_pri[v]);
      w[31:29] = 3'(m_sel[v]);
      w[24]    = m_pend[v];
    end
    return w;
  endfunction

  task automatic compare_all();
    logic [63:0] ms = '0, ss = '0;
    logic [5:0] ln;
    int v = int'(rd_idx);
    ms[47] = m_stat[0];
    ms[46] = m_stat[1];
    for (int i = 2; i < 7; i++) ss[36 - (i - 2)] = m_stat[i];
    for (int l = 0; l < 6; l++) ln[l] = m_line[l];
    chk("R4/R5/R6/R9 line_out", 64'(line_out), 64'(ln));
    chk("R3 mux_stat_word", mux_stat_word, ms);
    chk("R3 src_stat_word", src_stat_word, ss);
    chk("R1/R2/R7/R8 rd_data", rd_data, exp_word(v));
    chk("R10 rd_server", 64'(rd_server), v < 6 ? 64'(m_srv[v] >> 2) : 64'd0);
    chk("R10 rd_prio", 64'(rd_prio), v < 6 ? 64'(m_pri[v]) : 64'd0);
  endtask

  task automatic model_reset();
    for (int v = 0; v < 6; v++) begin
      m_srv[v] = 0; m_pri[v] = 255; m_sel[v] = v; m_pend[v] = 0; m_line[v] = 0;
    end
    for (int i = 0; i < 7; i++) m_stat[i] = 0;
  endtask

  task automatic model_step();
    bit a [6];
    if (wr_en && wr_idx < 6) begin
      m_srv[wr_idx] = wr_data[55:40];
      m_pri[wr_idx] = wr_data[39:32];
      m_sel[wr_idx] = wr_data[31:29];
    end
    a[0] = irq_in[0] || irq_in[1];
    for (int v = 1; v < 6; v++) a[v] = irq_in[v + 1];
    for (int l = 0; l < 6; l++) m_line[l] = 0;
    for (int v = 0; v < 6; v++) begin
      if (a[v] && m_sel[v] < 6) m_line[m_sel[v]] = 1;
      m_pend[v] = a[v] && (m_pri[v] != 255);
    end
    for (int i = 0; i < 7; i++) m_stat[i] = irq_in[i];
  endtask

  function automatic logic [63:0] vec(int srv, int pri, int sel);
    logic [63:0] w = 64'hFF00_0000_1EFF_FFFF;
    w[55:40] = 16'(srv);
    w[39:32] = 8'(pri);
    w[31:29] = 3'(sel);
    return w;
  endfunction

  task automatic drive(int c);
    wr_en = 0;
    rd_idx = 3'($urandom_range(0, 7));
    if (c < 40) begin
      irq_in = '0;
      rd_idx = (c >= 20) ? 3'd3 : 3'd0;
      if (c >= 1 && c <= 6) irq_in[0] = 1;
      if (c >= 4 && c <= 16) irq_in[1] = 1;
      if (c >= 20 && c <= 36) irq_in[4] = 1;
      case (c)
        0:  begin wr_en = 1; wr_idx = 0; wr_data = vec(16'h1237, 5, 2); end
        12: begin wr_en = 1; wr_idx = 0; wr_data = vec(16'h1237, 255, 2); end
        20: begin wr_en = 1; wr_idx = 3; wr_data = vec(16'hBEEF, 1, 7); end
        26: begin wr_en = 1; wr_idx = 3; wr_data = vec(16'hBEEF, 1, 6); end
        30: begin wr_en = 1; wr_idx = 3; wr_data = vec(16'hBEEF, 1, 0); end
        34: begin wr_en = 1; wr_idx = 7; wr_data = vec(16'h5555, 3, 1); end
        default: ;
      endcase
    end else begin
      irq_in = ($urandom_range(0, 3) == 0) ? 7'd0 : 7'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1;
        wr_idx = 3'($urandom_range(0, 7));
        wr_data = {$urandom, $urandom};
        if ($urandom_range(0, 2) == 0) wr_data[39:32] = 8'hFF;
      end
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all();
    rd_idx = 3'd5;
    #0 compare_all();
    rst_n = 1;
    drive(0);
    model_step();
    for (int c = 1; c < 3000; c++) begin
      @(negedge clk);
      compare_all();
      drive(c);
      model_step();
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule